// File: doc/BRIEF.md
# Vector Word Broadcast Unit

This unit executes a single vector operation: it takes one 128-bit register, picks one of its four 32-bit words, and writes that word into all four word positions of a destination register. Instruction words arrive one per cycle on a valid/ready stream. The unit decodes two instruction layouts. The short layout can reach only registers 0 to 31. The wide layout builds 7-bit register numbers from two separate fields each, so it can reach all 128 registers.

The 128-entry by 128-bit register file sits inside the unit. A test port can write any register and read any register back asynchronously, so a bench can preload operands and check results. An accepted word that matches neither layout raises a one-cycle illegal flag and changes no register. Bit numbering in the field descriptions below counts bit 0 as the most significant bit of the 32-bit word. Word 0 of a register is bits 127:96.

Back-pressure rule: a word transfers on a rising edge where `instr_valid` and `instr_ready` are both high. `instr_ready` is low in any cycle where the test port writes (`tp_wr_en` high), because the register file has one port for such writes. A word offered while ready is low is not taken and has no effect. The sender may hold it or withdraw it.

Top module: `vsplat_word_unit`

## Requirements
- R1: Short layout: primary opcode 4 in bits 0–5 and value 652 in bits 21–31 (word `0x1000028C` when every other field is zero). The destination is bits 6–10 and the source is bits 16–20. The destination receives the selected source word in all four word positions.
- R2: Wide layout: primary opcode 6 in bits 0–5 and value 0x73 in bits 21–27 (`0x18000730` when every other field is zero). The destination is {bits 28–29, bits 6–10} and the source is {bits 30–31, bits 16–20}, high part first, so registers 32–127 can be reached.
- R3: The word selector is the two least significant bits of the field in bits 11–15. Value 0 selects register bits 127:96 and value 3 selects bits 31:0.
- R4: The upper three bits of the selector field have no effect on the result.
- R5: An accepted word that matches neither layout drives `illegal_o` high for exactly the cycle after the acceptance edge and writes no register. In every other cycle `illegal_o` is low.
- R6: The result of a word accepted at edge k is written at edge k+1. `tp_rdata` shows it from then on, and the destination keeps its old value until that edge.
- R7: When the source and the destination are the same register, the result is formed from the value the register held before the write.
- R8: A word accepted on the edge right after another word sees that word's result as its source, even though the result is not yet written.
- R9: Only the destination register changes. All other registers keep their values.
- R10: `instr_ready` is the inverse of `tp_wr_en`. A word offered while ready is low is not accepted.
- R11: Reset clears every register to zero, clears any pending write and drives `illegal_o` low.
- R12: A test-port write lands at the same edge. If it hits the same register as a result written at that edge, the test-port data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit can take a word this cycle |
| instr_word | input | 32 | Instruction word |
| illegal_o | output | 1 | Previous accepted word was not recognised |
| tp_wr_en | input | 1 | Test-port write strobe |
| tp_addr | input | 7 | Test-port register number (write and read) |
| tp_wdata | input | 128 | Test-port write data |
| tp_rdata | output | 128 | Current contents of register `tp_addr` |

## Verification
The bench keeps its own architectural register image and a one-deep list of pending writes. Against these it checks every clock, at the register being watched, each of the following cases:
- **Back-to-back dependent words.** A unit without forwarding would read the stale source and store the wrong word.
- **Source equal to destination.** A wrong design would store a value from after the write.
- **Selector upper bits set.** A unit that decoded those bits would pick the wrong word or report the word as illegal.
- **Wide-layout registers above 31.** Swapping or dropping the split index halves would write the wrong register.
- **Near-miss words.** Words with a wrong extended value or opcode must raise the illegal flag and write nothing.
- **Result landing on the same edge as a test-port write.** The test-port data must win.
- **Stalled offer while the test port writes.** A unit that accepted this word would change a register.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

  localparam int INSN_W     = 32;
  localparam int REG_IDX_W  = 7;
  localparam int SHORT_IDX_W = 5;
  localparam int SEL_W      = 2;

  localparam logic [5:0]  OP_SHORT = 6'd4;
  localparam logic [5:0]  OP_WIDE  = 6'd6;
  localparam logic [10:0] XO_SHORT = 11'd652;
  localparam logic [6:0]  XO_WIDE  = 7'h73;

  typedef enum logic [1:0] {
    FMT_NONE  = 2'd0,
    FMT_SHORT = 2'd1,
    FMT_WIDE  = 2'd2
  } fmt_e;

  typedef struct packed {
    fmt_e                  fmt;
    logic                  legal;
    logic [REG_IDX_W-1:0]  dst;
    logic [REG_IDX_W-1:0]  src;
    logic [SEL_W-1:0]      sel;
  } dec_t;

endpackage

// File: rtl/vsw_decoder.sv
module vsw_decoder
  import vsw_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output dec_t              dec
);

  logic [5:0]             primary;
  logic                   hit_short;
  logic                   hit_wide;
  logic [SHORT_IDX_W-1:0] dst_lo;
  logic [SHORT_IDX_W-1:0] src_lo;
  logic [1:0]             dst_hi;
  logic [1:0]             src_hi;

  // Bit 0 of the encoding is word[31].
  always_comb begin
    primary   = word[31:26];
    dst_lo    = word[25:21];
    src_lo    = word[15:11];
    dst_hi    = word[3:2];
    src_hi    = word[1:0];
    hit_short = (primary == OP_SHORT) && (word[10:0] == XO_SHORT);
    hit_wide  = (primary == OP_WIDE)  && (word[10:4] == XO_WIDE);
  end

  always_comb begin
    dec       = '0;
    dec.sel   = word[16 +: SEL_W];   // upper selector bits dropped (R4)
    dec.fmt   = FMT_NONE;
    dec.legal = 1'b0;
    if (hit_short) begin
      dec.fmt   = FMT_SHORT;
      dec.legal = 1'b1;
      dec.dst   = {{(REG_IDX_W-SHORT_IDX_W){1'b0}}, dst_lo};
      dec.src   = {{(REG_IDX_W-SHORT_IDX_W){1'b0}}, src_lo};
    end else if (hit_wide) begin
      dec.fmt   = FMT_WIDE;
      dec.legal = 1'b1;
      dec.dst   = {dst_hi, dst_lo};
      dec.src   = {src_hi, src_lo};
    end
  end

endmodule

// File: rtl/vsw_splat.sv
module vsw_splat #(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  localparam int VEC_W = LANE_W * LANES,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [VEC_W-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic [VEC_W-1:0] result
);

  logic [LANE_W-1:0] lane [LANES];
  logic [LANE_W-1:0] picked;

  // Lane 0 is the most significant word (R3).
  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign lane[g] = src[(LANES-1-g)*LANE_W +: LANE_W];
  end

  assign picked = lane[sel];

  for (genvar g = 0; g < LANES; g++) begin : g_fill
    assign result[g*LANE_W +: LANE_W] = picked;
  end

endmodule

// File: rtl/vsw_regfile.sv
module vsw_regfile #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_en,
  input  logic [AW-1:0]    wb_addr,
  input  logic [WIDTH-1:0] wb_data,
  input  logic             tp_we,
  input  logic [AW-1:0]    tp_addr,
  input  logic [WIDTH-1:0] tp_wdata,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] tp_rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wb_en) mem[wb_addr] <= wb_data;
      // later assignment: test port wins a same-address collision (R12)
      if (tp_we) mem[tp_addr] <= tp_wdata;
    end
  end

  assign rd_data  = mem[rd_addr];
  assign tp_rdata = mem[tp_addr];

  p_wb_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !(tp_we && tp_addr == wb_addr)) |=> (mem[$past(wb_addr)] == $past(wb_data)));

endmodule

// File: rtl/vsplat_word_unit.sv
module vsplat_word_unit
  import vsw_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  localparam int VEC_W = LANE_W * LANES,
  localparam int REGS  = 1 << REG_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  output logic                 instr_ready,
  input  logic [INSN_W-1:0]    instr_word,
  output logic                 illegal_o,
  input  logic                 tp_wr_en,
  input  logic [REG_IDX_W-1:0] tp_addr,
  input  logic [VEC_W-1:0]     tp_wdata,
  output logic [VEC_W-1:0]     tp_rdata
);

  dec_t                 dec;
  logic                 accept;
  logic [VEC_W-1:0]     rf_src;
  logic [VEC_W-1:0]     src_val;
  logic [VEC_W-1:0]     splat_val;
  logic                 wb_valid;
  logic [REG_IDX_W-1:0] wb_addr;
  logic [VEC_W-1:0]     wb_data;
  logic                 illegal_q;

  // R10: the single test-port write slot blocks acceptance
  assign instr_ready = !tp_wr_en;
  assign accept      = instr_valid && instr_ready;

  vsw_decoder u_dec (
    .word (instr_word),
    .dec  (dec)
  );

  vsw_regfile #(.DEPTH(REGS), .WIDTH(VEC_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_en    (wb_valid),
    .wb_addr  (wb_addr),
    .wb_data  (wb_data),
    .tp_we    (tp_wr_en),
    .tp_addr  (tp_addr),
    .tp_wdata (tp_wdata),
    .rd_addr  (dec.src),
    .rd_data  (rf_src),
    .tp_rdata (tp_rdata)
  );

  // R8: forward the pending result; R7 falls out of reading before write-back
  assign src_val = (wb_valid && wb_addr == dec.src) ? wb_data : rf_src;

  vsw_splat #(.LANE_W(LANE_W), .LANES(LANES)) u_splat (
    .src    (src_val),
    .sel    (dec.sel),
    .result (splat_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
      illegal_q <= 1'b0;
    end else begin
      wb_valid  <= accept && dec.legal;
      illegal_q <= accept && !dec.legal;
      if (accept && dec.legal) begin
        wb_addr <= dec.dst;
        wb_data <= splat_val;
      end
    end
  end

  assign illegal_o = illegal_q;

  p_illegal_from_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $past(instr_valid && !tp_wr_en));

  p_illegal_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !wb_valid);

  p_wb_from_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(instr_valid && !tp_wr_en));

endmodule

// File: tb/test_vsplat_word_unit.sv
module test_vsplat_word_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         instr_valid = 1'b0;
  logic         instr_ready;
  logic [31:0]  instr_word = '0;
  logic         illegal_o;
  logic         tp_wr_en = 1'b0;
  logic [6:0]   tp_addr = '0;
  logic [127:0] tp_wdata = '0;
  logic [127:0] tp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsplat_word_unit i_vsplat_word_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .illegal_o(illegal_o), .tp_wr_en(tp_wr_en),
    .tp_addr(tp_addr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string req = "R11";

  // behavioural reference: architectural image plus visible image lagging by one write
  logic [127:0] arch [128];
  logic [127:0] vis  [128];
  logic         pend_v = 1'b0;
  logic [6:0]   pend_a = '0;
  logic [127:0] pend_d = '0;
  logic         exp_ill = 1'b0;

  function automatic logic [31:0] w_short(int d, int s, int imm);
    return (32'd4 << 26) | (32'(d) << 21) | (32'(imm) << 16) | (32'(s) << 11) | 32'd652;
  endfunction

  function automatic logic [31:0] w_wide(int d, int s, int imm);
    return (32'd6 << 26) | (32'(d % 32) << 21) | (32'(imm) << 16) | (32'(s % 32) << 11)
         | (32'h73 << 4) | (32'(d / 32) << 2) | 32'(s / 32);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) begin arch[i] = '0; vis[i] = '0; end
      pend_v = 1'b0; exp_ill = 1'b0;
    end else begin
      logic [31:0] w;
      int d, s, sel;
      logic ok;
      logic [31:0] pick;
      if (pend_v) vis[pend_a] = pend_d;
      pend_v = 1'b0;
      if (tp_wr_en) begin vis[tp_addr] = tp_wdata; arch[tp_addr] = tp_wdata; end
      exp_ill = 1'b0;
      if (instr_valid && !tp_wr_en) begin
        w = instr_word; ok = 1'b0; d = 0; s = 0;
        if (w[31:26] == 6'd4 && w[10:0] == 11'd652) begin
          ok = 1'b1; d = int'(w[25:21]); s = int'(w[15:11]);
        end else if (w[31:26] == 6'd6 && w[10:4] == 7'h73) begin
          ok = 1'b1; d = int'(w[3:2]) * 32 + int'(w[25:21]); s = int'(w[1:0]) * 32 + int'(w[15:11]);
        end
        if (ok) begin
          sel  = int'(w[17:16]);
          pick = arch[s][127 - 32*sel -: 32];
          arch[d] = {pick, pick, pick, pick};
          pend_v = 1'b1; pend_a = 7'(d); pend_d = arch[d];
        end else exp_ill = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (illegal_o !== exp_ill) begin
        fails++; $display("FAIL %s illegal_o: actual %b expected %b", req, illegal_o, exp_ill);
      end
      checks++;
      if (tp_rdata !== vis[tp_addr]) begin
        fails++; $display("FAIL %s reg %0d: actual %h expected %h", req, tp_addr, tp_rdata, vis[tp_addr]);
      end
      checks++;
      if (instr_ready !== !tp_wr_en) begin
        fails++; $display("FAIL R10 instr_ready: actual %b expected %b", instr_ready, !tp_wr_en);
      end
    end
    if (cycles > WATCHDOG) begin
      fails++; $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tp_write(int a, logic [127:0] v);
    tp_wr_en = 1'b1; tp_addr = 7'(a); tp_wdata = v; step(); tp_wr_en = 1'b0;
  endtask

  task automatic issue(logic [31:0] w, int watch);
    instr_valid = 1'b1; instr_word = w; tp_addr = 7'(watch); step();
    instr_valid = 1'b0; step(); step();
  endtask

  task automatic scan();
    for (int a = 0; a < 128; a++) begin tp_addr = 7'(a); step(); end
  endtask

  initial begin
    // R11: reset state
    step(); step(); rst_n = 1'b1;
    req = "R11"; scan();

    // R12: preload and readback
    req = "R12";
    for (int a = 0; a < 128; a++)
      tp_write(a, {32'(a) ^ 32'hA0000000, 32'(a) ^ 32'hB1000000, 32'(a) ^ 32'hC2000000, 32'(a) ^ 32'hD3000000});
    scan();

    // R1 / R3: short layout, every selector
    req = "R1";
    issue(w_short(5, 9, 0), 5);
    req = "R3";
    issue(w_short(6, 9, 1), 6);
    issue(w_short(7, 9, 2), 7);
    issue(w_short(8, 9, 3), 8);

    // R4: upper selector bits ignored
    req = "R4";
    issue(w_short(11, 12, 5'b11101), 11);
    issue(w_short(13, 12, 5'b10010), 13);

    // R2: wide layout above register 31, both halves of both indices
    req = "R2";
    issue(w_wide(100, 45, 2), 100);
    issue(w_wide(33, 127, 3), 33);
    issue(w_wide(64, 3, 0), 64);

    // R5: near-miss words flagged, nothing written
    req = "R5";
    issue(32'h1000028D, 0);
    issue(32'h18000720, 0);
    issue(32'h14000730, 0);
    issue(w_short(20, 21, 1) ^ 32'h00000400, 20);

    // R7: source equals destination
    req = "R7";
    issue(w_short(15, 15, 3), 15);
    issue(w_wide(90, 90, 1), 90);

    // R8 / R6: back-to-back dependent words, watching the second destination
    req = "R8";
    tp_addr = 7'd41;
    instr_valid = 1'b1; instr_word = w_short(30, 2, 0); step();
    instr_word = w_wide(41, 30, 2); step();
    instr_word = w_wide(42, 41, 1); step();
    instr_valid = 1'b0; step(); step();
    req = "R6";
    tp_addr = 7'd50;
    instr_valid = 1'b1; instr_word = w_wide(50, 60, 0); step();
    instr_valid = 1'b0; step(); step();

    // R10: offer while the test port writes is not accepted
    req = "R10";
    instr_valid = 1'b1; instr_word = w_short(3, 4, 0);
    tp_wr_en = 1'b1; tp_addr = 7'd70; tp_wdata = {4{32'h5A5A5A5A}}; step();
    tp_wr_en = 1'b0; instr_valid = 1'b0; tp_addr = 7'd3; step(); step();

    // R12: test-port write on the same edge as a result to the same register
    req = "R12";
    tp_addr = 7'd77;
    instr_valid = 1'b1; instr_word = w_wide(77, 1, 0); step();
    instr_valid = 1'b0; tp_wr_en = 1'b1; tp_wdata = {4{32'hDEADBEEF}}; step();
    tp_wr_en = 1'b0; step(); step();

    // R9: no other register disturbed
    req = "R9"; scan();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule